// File: doc/BRIEF.md
# SAR Conversion and Power Sequencer

This block is the digital control core of a successive-approximation converter. A single active-low convert-start line drives it. A rising edge wakes the block from its low-current state. A falling edge places the track/hold in hold and launches a bit-by-bit binary search. In each bit period the block drives a trial code toward the DAC and reads back one comparator bit. When the search finishes, the block hands the completed code to the output shift register with a one-cycle strobe.

At the moment the last bit is decided, the block reads the level of the convert-start line. If the line is high, the block stays powered and can start the next conversion right away, after a short acquisition interval. If the line is low, the block drops its power enable at once and waits for the next rising edge. A narrow start pulse cannot cut the power-up short. The block finishes the power-up count internally and only then begins the conversion. A serial-read-busy input holds the result in the block while a read of the older value is still shifting out.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, pwr_en, hold, busy and result_valid are low and result is zero.
- R2: A rising edge of conv_start_n while powered down raises pwr_en one cycle later. If conv_start_n falls before power-up completes, hold rises exactly PWRUP_CYC cycles after pwr_en rose. A conversion never starts earlier than that.
- R3: If conv_start_n falls after power-up has completed, hold rises on the next cycle.
- R4: hold stays high for exactly W*BIT_CYC cycles. busy is high whenever hold is high and falls in the same cycle that result_valid rises.
- R5: result is straight binary. With cmp_ge high exactly when the analog input is at or above dac_code, result equals the largest code for which the comparator reports at-or-above. For an ideal comparator this is the input code itself, from 0 to 2^W-1.
- R6: The search runs MSB first. The first trial code is 2^(W-1). At the end of each bit period the bit under trial is kept when cmp_ge is high and cleared otherwise. The next lower bit is then set for trial.
- R7: If conv_start_n is high when the last bit is decided, pwr_en stays high after the result is latched. A later falling edge then starts hold on the next cycle without any power-up delay.
- R8: If conv_start_n is low when the last bit is decided, pwr_en falls on the next cycle. Until a new rising edge arrives, pwr_en and hold stay low.
- R9: While rd_busy is high after the search ends, result_valid stays low and result keeps its old value. The latch happens on the first cycle in which rd_busy is sampled low.
- R10: Edges of conv_start_n during a conversion are ignored. The hold length is unchanged and no extra conversion follows.
- R11: result_valid is high for one cycle at a time, and result changes only in the cycle in which result_valid is high.
- R12: In powered mode, hold does not rise earlier than ACQ_CYC cycles after result_valid. A falling edge that arrives inside this window is remembered and served when the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Active-low convert start: rise wakes, fall starts hold |
| cmp_ge | input | 1 | Comparator: input at or above dac_code |
| rd_busy | input | 1 | A serial read of the previous result is in progress |
| dac_code | output | W | Trial code driven to the DAC |
| hold | output | 1 | 1 = hold, 0 = track |
| pwr_en | output | 1 | Analog power enable |
| result | output | W | Last latched conversion code |
| result_valid | output | 1 | One-cycle strobe when result is loaded |
| busy | output | 1 | From start of hold until the result is latched |

## Verification
A wrong internal state shows up at the ports within one bit period. A corrupted trial mask or accumulator changes dac_code at the next step and gives a wrong result for the code under test. A full sweep of all input codes exposes any stuck or swapped bit. Errors in the power and timer state appear as a hold edge that comes a cycle early or late relative to pwr_en or result_valid, or as pwr_en that fails to drop or hold on. The bench measures these distances in cycles.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_PWRUP  = 3'd1,
      ST_READY  = 3'd2,
      ST_SEARCH = 3'd3,
      ST_FINISH = 3'd4
   } seq_state_e;
endpackage

// File: rtl/sar_edge_det.sv
`timescale 1ns/1ps
// Edge detector with an optional synchronizer chain in front.
module sar_edge_det #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '0;
            end else begin
               sync_q[0] <= din;
               for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign level = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
endmodule

// File: rtl/sar_timer.sv
`timescale 1ns/1ps
// Loadable down counter that parks at zero.
module sar_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sar_search.sv
`timescale 1ns/1ps
// Binary search register: one-hot trial mask walking from MSB to LSB.
module sar_search #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         step,
   input  logic         cmp_ge,
   output logic [W-1:0] trial,
   output logic [W-1:0] acc,
   output logic         last
);
   logic [W-1:0] mask_q;
   logic [W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         acc_q  <= '0;
      end else if (start) begin
         mask_q <= {1'b1, {(W-1){1'b0}}};
         acc_q  <= '0;
      end else if (step) begin
         if (cmp_ge) acc_q <= acc_q | mask_q;
         mask_q <= mask_q >> 1;
      end
   end

   assign trial = acc_q | mask_q;
   assign acc   = acc_q;
   assign last  = mask_q[0];
endmodule

// File: rtl/sar_conv_seq.sv
`timescale 1ns/1ps
// Conversion and power sequencer for a successive-approximation converter.
module sar_conv_seq
   import sar_seq_pkg::*;
#(
   parameter int W           = 8,
   parameter int PWRUP_CYC   = 200,
   parameter int BIT_CYC     = 100,
   parameter int ACQ_CYC     = 20,
   parameter int SYNC_STAGES = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         conv_start_n,
   input  logic         cmp_ge,
   input  logic         rd_busy,
   output logic [W-1:0] dac_code,
   output logic         hold,
   output logic         pwr_en,
   output logic [W-1:0] result,
   output logic         result_valid,
   output logic         busy
);
   localparam int TMAX = (PWRUP_CYC > ACQ_CYC) ? PWRUP_CYC : ACQ_CYC;
   localparam int TW   = $clog2(TMAX + 1);
   localparam int BW   = $clog2(BIT_CYC + 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("sar_conv_seq: W must be at least 2");
      end
      if (PWRUP_CYC < 1 || BIT_CYC < 1 || ACQ_CYC < 1) begin : g_bad_cyc
         $error("sar_conv_seq: cycle counts must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sar_conv_seq: SYNC_STAGES must not be negative");
      end
   endgenerate

   seq_state_e   state_q, state_d;
   logic         cs_level, cs_rise, cs_fall;
   logic         pend_q, keep_q;
   logic         tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic         bit_load, bit_zero;
   logic         begin_conv, latch, step, eoc;
   logic         srch_last;
   logic [W-1:0] srch_acc, srch_trial;
   logic [W-1:0] result_q;
   logic         valid_q;

   sar_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (conv_start_n),
      .level (cs_level),
      .rise  (cs_rise),
      .fall  (cs_fall)
   );

   // Shared timer: power-up count, then acquisition window.
   sar_timer #(.CW(TW)) u_ptmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sar_timer #(.CW(BW)) u_btmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (bit_load),
      .load_val (BW'(BIT_CYC - 1)),
      .zero     (bit_zero)
   );

   sar_search #(.W(W)) u_srch (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (begin_conv),
      .step   (step),
      .cmp_ge (cmp_ge),
      .trial  (srch_trial),
      .acc    (srch_acc),
      .last   (srch_last)
   );

   assign step     = (state_q == ST_SEARCH) && bit_zero;
   assign eoc      = step && srch_last;
   assign bit_load = begin_conv | step;

   always_comb begin
      state_d    = state_q;
      begin_conv = 1'b0;
      latch      = 1'b0;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      case (state_q)
         ST_OFF: begin
            if (cs_rise) begin
               state_d  = ST_PWRUP;
               tmr_load = 1'b1;
               tmr_val  = TW'(PWRUP_CYC - 1);
            end
         end
         ST_PWRUP: begin
            if (tmr_zero) begin
               if (pend_q || cs_fall) begin
                  begin_conv = 1'b1;
                  state_d    = ST_SEARCH;
               end else begin
                  state_d = ST_READY;
               end
            end
         end
         ST_READY: begin
            if (tmr_zero && (pend_q || cs_fall)) begin
               begin_conv = 1'b1;
               state_d    = ST_SEARCH;
            end
         end
         ST_SEARCH: begin
            if (eoc) state_d = ST_FINISH;
         end
         ST_FINISH: begin
            if (!rd_busy) begin
               latch = 1'b1;
               if (keep_q) begin
                  state_d  = ST_READY;
                  tmr_load = 1'b1;
                  tmr_val  = TW'(ACQ_CYC - 1);
               end else begin
                  state_d = ST_OFF;
               end
            end
         end
         default: state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_OFF;
         pend_q   <= 1'b0;
         keep_q   <= 1'b0;
         result_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_q <= latch;
         if (latch) result_q <= srch_acc;
         if (eoc) keep_q <= cs_level;
         if (begin_conv || state_d == ST_OFF)
            pend_q <= 1'b0;
         else if ((state_q == ST_PWRUP || state_q == ST_READY) && cs_fall)
            pend_q <= 1'b1;
      end
   end

   assign dac_code     = srch_trial;
   assign hold         = (state_q == ST_SEARCH);
   assign busy         = (state_q == ST_SEARCH) || (state_q == ST_FINISH);
   assign pwr_en       = (state_q != ST_OFF) && !((state_q == ST_FINISH) && !keep_q);
   assign result       = result_q;
   assign result_valid = valid_q;
endmodule

// File: rtl/sar_conv_seq_chk.sv
`timescale 1ns/1ps
module sar_conv_seq_chk #(
   parameter int W           = 8,
   parameter int PWRUP_CYC   = 200,
   parameter int BIT_CYC     = 100,
   parameter int ACQ_CYC     = 20,
   parameter int SYNC_STAGES = 0
) (
   input logic         clk,
   input logic         rst_n,
   input logic         rd_busy,
   input logic [W-1:0] dac_code,
   input logic         hold,
   input logic         pwr_en,
   input logic [W-1:0] result,
   input logic         result_valid,
   input logic         busy
);
   localparam int HLEN = W * BIT_CYC;
   localparam int HC_W = $clog2(HLEN + 2);

   logic [HC_W-1:0] hold_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_cnt <= '0;
      else if (hold) hold_cnt <= hold_cnt + 1'b1;
      else           hold_cnt <= '0;
   end

   a_r4_hold_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> busy);
   a_r4_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold) |-> (hold_cnt == HC_W'(HLEN)));
   a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);
   a_r11_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> $stable(result));
   a_r2_hold_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold) |-> $past(pwr_en));
   a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold) |-> (dac_code == {1'b1, {(W-1){1'b0}}}));
   a_r9_defer: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hold && rd_busy) |=> !result_valid);
   a_r8_no_hold_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> !hold);
endmodule

bind sar_conv_seq sar_conv_seq_chk #(
   .W(W), .PWRUP_CYC(PWRUP_CYC), .BIT_CYC(BIT_CYC),
   .ACQ_CYC(ACQ_CYC), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rd_busy      (rd_busy),
   .dac_code     (dac_code),
   .hold         (hold),
   .pwr_en       (pwr_en),
   .result       (result),
   .result_valid (result_valid),
   .busy         (busy)
);

// File: tb/tb_sar_conv_seq.sv
`timescale 1ns/1ps
module tb_sar_conv_seq;
   localparam int W  = 8;
   localparam int PU = 5;
   localparam int BC = 2;
   localparam int AQ = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         conv_n = 1'b0;
   logic         rd_busy = 1'b0;
   logic [W-1:0] vin = '0;
   logic         cmp_ge;
   logic [W-1:0] dac_code, result;
   logic         hold, pwr_en, result_valid, busy;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   // Behavioural comparator: input code at or above trial code.
   assign cmp_ge = (vin >= dac_code);

   sar_conv_seq #(
      .W(W), .PWRUP_CYC(PU), .BIT_CYC(BC), .ACQ_CYC(AQ), .SYNC_STAGES(0)
   ) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .conv_start_n (conv_n),
      .cmp_ge       (cmp_ge),
      .rd_busy      (rd_busy),
      .dac_code     (dac_code),
      .hold         (hold),
      .pwr_en       (pwr_en),
      .result       (result),
      .result_valid (result_valid),
      .busy         (busy)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic wait_hold(output int n);
      n = 0;
      while (!hold && n < 500) begin tick; n++; end
   endtask

   task automatic wait_valid(output int n, output int hc);
      n = 0; hc = 0;
      while (!result_valid && n < 2000) begin
         if (hold) hc++;
         tick; n++;
      end
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=done");
         summary;
         $finish;
      end
   end

   initial begin
      int n, hc, total, seen, prev;
      repeat (3) tick;
      rst_n = 1'b1;
      tick;
      // R1 reset state
      chk("R1 pwr_en", pwr_en, 0);
      chk("R1 hold", hold, 0);
      chk("R1 busy", busy, 0);
      chk("R1 result_valid", result_valid, 0);
      chk("R1 result", result, 0);

      // R2 narrow start pulse, auto power-down afterwards
      vin = 8'hA5;
      conv_n = 1'b1; tick;
      chk("R2 pwr_en after rise", pwr_en, 1);
      conv_n = 1'b0;
      wait_hold(n);
      chk("R2 power-up cycles", n, PU);
      chk("R6 first trial", dac_code, 128);
      repeat (BC) tick;
      chk("R6 second trial", dac_code, 8'hC0);
      wait_valid(n, hc);
      total = hc + BC;
      chk("R5 result A5", result, 8'hA5);
      chk("R4 busy clear at latch", busy, 0);
      chk("R4 hold length", total, W * BC);
      chk("R8 pwr_en off", pwr_en, 0);
      tick;
      chk("R11 strobe one cycle", result_valid, 0);
      seen = 0;
      repeat (6) begin tick; seen += hold + pwr_en; end
      chk("R8 stays off", seen, 0);

      // R3 wide start pulse
      vin = 8'h3C;
      conv_n = 1'b1;
      repeat (PU + 3) tick;
      chk("R3 hold before fall", hold, 0);
      conv_n = 1'b0; tick;
      chk("R3 hold next cycle", hold, 1);
      wait_valid(n, hc);
      chk("R5 result 3C", result, 8'h3C);
      tick;
      chk("R8 off after low level", pwr_en, 0);

      // R7 / R12 powered mode
      vin = 8'h7F;
      conv_n = 1'b1;
      repeat (PU + 2) tick;
      conv_n = 1'b0; tick;
      conv_n = 1'b1;
      wait_valid(n, hc);
      chk("R5 result 7F", result, 8'h7F);
      chk("R7 stays powered", pwr_en, 1);
      vin = 8'h81;
      conv_n = 1'b0;
      wait_hold(n);
      chk("R12 acquisition wait", n, AQ);
      // R10 edges during conversion are ignored
      tick; conv_n = 1'b1;
      tick; conv_n = 1'b0;
      tick; conv_n = 1'b1;
      wait_valid(n, hc);
      chk("R10 hold length", hc + 3, W * BC);
      chk("R5 result 81", result, 8'h81);
      seen = 0;
      repeat (AQ + 6) begin tick; seen += hold; end
      chk("R10 no extra conversion", seen, 0);
      chk("R7 still powered", pwr_en, 1);
      vin = 8'h5A;
      conv_n = 1'b0; tick;
      chk("R7 no power-up delay", hold, 1);
      conv_n = 1'b1;

      // R9 read in progress defers latch
      prev = result;
      rd_busy = 1'b1;
      while (hold) tick;
      seen = 0;
      repeat (5) begin
         seen += result_valid;
         if (result != prev) seen++;
         tick;
      end
      chk("R9 latch deferred", seen, 0);
      rd_busy = 1'b0; tick;
      chk("R9 strobe after read", result_valid, 1);
      chk("R9 result 5A", result, 8'h5A);

      // R5 full code sweep in powered mode
      for (int code = 0; code < 256; code++) begin
         vin = code[W-1:0];
         repeat (AQ + 1) tick;
         conv_n = 1'b0; tick;
         conv_n = 1'b1;
         wait_valid(n, hc);
         chk("R5 sweep", result, code);
      end

      finished = 1'b1;
      summary;
      $finish;
   end
endmodule